// File: doc/BRIEF.md
# Shared-Memory Multi-Queue Token Manager

This block runs several independent circular queues inside one shared, word-addressed storage array. Each queue owns a region described by a start word, a length in words, a token length of one to four words and an enable flag. A client writes one whole token into a queue's tail through the push port. Another client takes one whole token from a queue's head through the pop port, and the result comes back one cycle later.

The block reports how many more tokens each queue can take. It keeps wrapping totals of accepted pushes and accepted pops over all queues. It keeps two sticky error flags: one for a push to a full queue and one for a pop from an empty queue. Each flag has its own enable mask and its own force input, and the interrupt line is the OR of the enabled flags. A push and a pop aimed at the same queue in the same cycle never share the storage port: the push goes first and the pop is held back one cycle.

Top module: `tokq_mgr`

## Requirements
- R1: The token size code maps to a token length: 0 is 1 word, 1 is 2 words, 2 is 3 words and 3 is 4 words. A push stores the first (code+1) words of `push_data_i`, where word k sits at bits [k*DATA_W +: DATA_W]. A pop returns those words at the same positions and zero in every word above the token length.
- R2: Each queue is first-in first-out. Head and tail advance by the token length and return to word 0 when they reach the configured size. A queue whose size is a whole multiple of the token length holds size/length tokens.
- R3: The words of a token are stored at the queue's start word plus its pointer, modulo MEM_WORDS. Queues whose regions overlap therefore see each other's words.
- R4: A configuration write to a queue sets its head, tail and token count to zero, so the queue shows full free space. A push or pop to that queue in the same cycle is dropped without a flag.
- R5: While a queue's enable is 0, a push to it is dropped. A pop from it gives a response with `pop_ok_o`=0 and zero data. Neither changes a flag or a total.
- R6: A push to an enabled, full queue leaves its stored tokens unchanged and sets status bit 0 (push-full).
- R7: A pop from an enabled, empty queue returns zero data with `pop_ok_o`=0 and sets status bit 1 (pop-empty).
- R8: A status bit stays set until it is cleared by a 1 on the matching `irq_clr_i` bit. A 0 on that bit does not clear it. If a bit is set and cleared in the same cycle, it stays set.
- R9: A 1 on an `irq_test_i` bit sets the matching status bit on the next clock edge. `irq_o` is the OR of the status bits whose `irq_mask_i` bit is 1.
- R10: For each queue, `space_o` gives the number of tokens it can still accept: size/length minus tokens held. The value is updated on the clock edge that accepts the operation.
- R11: `push_total_o` and `pop_total_o` count only accepted pushes and accepted pops. They wrap modulo 2^CNT_W.
- R12: When a push and a pop name the same queue in the same cycle, `pop_ready_o` is 0 and the push is served. The pop, if held, is served in the following cycle.
- R13: Each pop taken while `pop_ready_o` is 1 gives exactly one cycle of `pop_rsp_o` on the next clock edge, together with `pop_ok_o` and `pop_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_q_i | input | $clog2(NUM_Q) | Queue selected for configuration |
| cfg_en_i | input | 1 | Queue enable value |
| cfg_tsize_i | input | 2 | Token size code |
| cfg_start_i | input | $clog2(MEM_WORDS) | Region start word |
| cfg_size_i | input | $clog2(MEM_WORDS)+1 | Region size in words |
| push_valid_i | input | 1 | Push request |
| push_q_i | input | $clog2(NUM_Q) | Push target queue |
| push_data_i | input | 4*DATA_W | Push token, word 0 in the low bits |
| pop_valid_i | input | 1 | Pop request |
| pop_q_i | input | $clog2(NUM_Q) | Pop source queue |
| pop_ready_o | output | 1 | Pop taken this cycle |
| pop_rsp_o | output | 1 | Pop result valid |
| pop_ok_o | output | 1 | Pop result carries a token |
| pop_data_o | output | 4*DATA_W | Popped token |
| space_o | output | NUM_Q*($clog2(MEM_WORDS)+1) | Free token space per queue |
| push_total_o | output | CNT_W | Accepted push total |
| pop_total_o | output | CNT_W | Accepted pop total |
| irq_mask_i | input | 2 | Interrupt enable per status bit |
| irq_test_i | input | 2 | Force status bits |
| irq_clr_i | input | 2 | Write-one-to-clear status bits |
| irq_sts_o | output | 2 | Sticky status (bit 0 push-full, bit 1 pop-empty) |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with NUM_Q=4, MEM_WORDS=32, DATA_W=16 and CNT_W=6. These values let every queue reach full within a few tokens. The 6-bit totals wrap several times during the random phase. The 32-word array is small enough to pack four regions with different token lengths, and to lay one region over another to expose start-word mapping. Directed phases cover every token size code, pointer wrap, disabled and reconfigured queues, the same-queue push/pop stall, and set-versus-clear on the flags. A long random phase with mixed queues, flag clears, forces and mask changes follows.

// File: rtl/tokq_pkg.sv
package tokq_pkg;
  localparam int TOK_MAX       = 4;
  localparam int IRQ_NB        = 2;
  localparam int IRQ_PUSH_FULL = 0;
  localparam int IRQ_POP_EMPTY = 1;
  typedef logic [1:0] tsize_t;
endpackage

// File: rtl/tokq_qstate.sv
module tokq_qstate
  import tokq_pkg::*;
#(
  parameter  int MEM_WORDS = 64,
  localparam int AW        = $clog2(MEM_WORDS),
  localparam int SW        = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_en_i,
  input  tsize_t        cfg_tsize_i,
  input  logic [AW-1:0] cfg_start_i,
  input  logic [SW-1:0] cfg_size_i,
  input  logic          push_do_i,
  input  logic          pop_do_i,
  output logic          en_o,
  output tsize_t        tsize_o,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] head_o,
  output logic [AW-1:0] tail_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [SW-1:0] space_o
);
  logic          en_q;
  tsize_t        tsize_q;
  logic [AW-1:0] start_q, head_q, tail_q, head_nx, tail_nx;
  logic [SW-1:0] size_q, cap_q, cnt_q, cap_d, step, head_inc, tail_inc;

  // token capacity of the region, computed once per configuration write
  always_comb begin
    unique case (cfg_tsize_i)
      2'd0:    cap_d = cfg_size_i;
      2'd1:    cap_d = cfg_size_i >> 1;
      2'd2:    cap_d = cfg_size_i / SW'(3);
      default: cap_d = cfg_size_i >> 2;
    endcase
  end

  assign step     = SW'(tsize_q) + SW'(1);
  assign head_inc = SW'(head_q) + step;
  assign tail_inc = SW'(tail_q) + step;
  assign head_nx  = (head_inc >= size_q) ? '0 : head_inc[AW-1:0];
  assign tail_nx  = (tail_inc >= size_q) ? '0 : tail_inc[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      tsize_q <= '0;
      start_q <= '0;
      size_q  <= '0;
      cap_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else if (cfg_we_i) begin
      en_q    <= cfg_en_i;
      tsize_q <= cfg_tsize_i;
      start_q <= cfg_start_i;
      size_q  <= cfg_size_i;
      cap_q   <= cap_d;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (push_do_i) tail_q <= tail_nx;
      if (pop_do_i)  head_q <= head_nx;
      if (push_do_i && !pop_do_i)      cnt_q <= cnt_q + SW'(1);
      else if (pop_do_i && !push_do_i) cnt_q <= cnt_q - SW'(1);
    end
  end

  assign en_o    = en_q;
  assign tsize_o = tsize_q;
  assign start_o = start_q;
  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (cnt_q == cap_q);
  assign empty_o = (cnt_q == '0);
  assign space_o = cap_q - cnt_q;

  assert_cnt_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cap_q);
  assert_ptr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_q != '0) |-> (SW'(head_q) < size_q && SW'(tail_q) < size_q));
  assert_cfg_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (head_q == '0 && tail_q == '0 && cnt_q == '0));
  assert_no_push_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_do_i |-> (cnt_q != cap_q));
  assert_no_pop_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_do_i |-> (cnt_q != '0));
endmodule

// File: rtl/tokq_mem.sv
module tokq_mem
  import tokq_pkg::*;
#(
  parameter  int MEM_WORDS = 64,   // power of two: addresses wrap naturally
  parameter  int DATA_W    = 32,
  localparam int AW        = $clog2(MEM_WORDS),
  localparam int TW        = TOK_MAX * DATA_W
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  tsize_t        wlen_i,
  input  logic [TW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  input  tsize_t        rlen_i,
  output logic [TW-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [MEM_WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int w = 0; w < TOK_MAX; w++) begin
        if (w <= int'(wlen_i)) mem_q[waddr_i + AW'(w)] <= wdata_i[w*DATA_W +: DATA_W];
      end
    end
  end

  for (genvar w = 0; w < TOK_MAX; w++) begin : g_rd
    assign rdata_o[w*DATA_W +: DATA_W] = (w <= int'(rlen_i)) ? mem_q[raddr_i + AW'(w)] : '0;
  end
endmodule

// File: rtl/tokq_irq.sv
module tokq_irq
  import tokq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IRQ_NB-1:0] set_i,
  input  logic [IRQ_NB-1:0] test_i,
  input  logic [IRQ_NB-1:0] clr_i,
  input  logic [IRQ_NB-1:0] mask_i,
  output logic [IRQ_NB-1:0] sts_o,
  output logic              irq_o
);
  logic [IRQ_NB-1:0] sts_q;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | set_i | test_i;
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & mask_i);

  for (genvar b = 0; b < IRQ_NB; b++) begin : g_chk
    assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_q[b] && !clr_i[b]) |=> sts_q[b]);
    assert_test_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      test_i[b] |=> sts_q[b]);
  end
endmodule

// File: rtl/tokq_mgr.sv
module tokq_mgr
  import tokq_pkg::*;
#(
  parameter  int NUM_Q     = 8,
  parameter  int MEM_WORDS = 64,
  parameter  int DATA_W    = 32,
  parameter  int CNT_W     = 16,
  localparam int QW        = $clog2(NUM_Q),
  localparam int AW        = $clog2(MEM_WORDS),
  localparam int SW        = AW + 1,
  localparam int TW        = TOK_MAX * DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [QW-1:0]       cfg_q_i,
  input  logic                cfg_en_i,
  input  logic [1:0]          cfg_tsize_i,
  input  logic [AW-1:0]       cfg_start_i,
  input  logic [SW-1:0]       cfg_size_i,
  input  logic                push_valid_i,
  input  logic [QW-1:0]       push_q_i,
  input  logic [TW-1:0]       push_data_i,
  input  logic                pop_valid_i,
  input  logic [QW-1:0]       pop_q_i,
  output logic                pop_ready_o,
  output logic                pop_rsp_o,
  output logic                pop_ok_o,
  output logic [TW-1:0]       pop_data_o,
  output logic [NUM_Q*SW-1:0] space_o,
  output logic [CNT_W-1:0]    push_total_o,
  output logic [CNT_W-1:0]    pop_total_o,
  input  logic [1:0]          irq_mask_i,
  input  logic [1:0]          irq_test_i,
  input  logic [1:0]          irq_clr_i,
  output logic [1:0]          irq_sts_o,
  output logic                irq_o
);
  logic [NUM_Q-1:0] q_en, q_full, q_empty;
  logic [NUM_Q-1:0] push_sel, pop_sel, cfg_sel, push_do, pop_do, push_err, pop_err;
  tsize_t           q_tsize [NUM_Q];
  logic [AW-1:0]    q_start [NUM_Q];
  logic [AW-1:0]    q_head  [NUM_Q];
  logic [AW-1:0]    q_tail  [NUM_Q];
  logic [AW-1:0]    waddr, raddr;
  tsize_t           wlen, rlen;
  logic [TW-1:0]    rdata;
  logic             pop_fire;
  logic [IRQ_NB-1:0] irq_set;

  // same-queue collision: push owns the storage port, pop waits a cycle
  assign pop_ready_o = !(push_valid_i && pop_valid_i && (push_q_i == pop_q_i));
  assign pop_fire    = pop_valid_i && pop_ready_o;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign push_sel[i] = push_valid_i && (push_q_i == QW'(i));
    assign pop_sel[i]  = pop_fire && (pop_q_i == QW'(i));
    assign cfg_sel[i]  = cfg_we_i && (cfg_q_i == QW'(i));
    assign push_do[i]  = push_sel[i] && !cfg_sel[i] && q_en[i] && !q_full[i];
    assign push_err[i] = push_sel[i] && !cfg_sel[i] && q_en[i] && q_full[i];
    assign pop_do[i]   = pop_sel[i] && !cfg_sel[i] && q_en[i] && !q_empty[i];
    assign pop_err[i]  = pop_sel[i] && !cfg_sel[i] && q_en[i] && q_empty[i];

    tokq_qstate #(.MEM_WORDS(MEM_WORDS)) u_qstate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_sel[i]),
      .cfg_en_i   (cfg_en_i),
      .cfg_tsize_i(cfg_tsize_i),
      .cfg_start_i(cfg_start_i),
      .cfg_size_i (cfg_size_i),
      .push_do_i  (push_do[i]),
      .pop_do_i   (pop_do[i]),
      .en_o       (q_en[i]),
      .tsize_o    (q_tsize[i]),
      .start_o    (q_start[i]),
      .head_o     (q_head[i]),
      .tail_o     (q_tail[i]),
      .full_o     (q_full[i]),
      .empty_o    (q_empty[i]),
      .space_o    (space_o[i*SW +: SW])
    );
  end

  always_comb begin
    waddr = '0;
    wlen  = '0;
    raddr = '0;
    rlen  = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (push_sel[i]) begin
        waddr = q_start[i] + q_tail[i];
        wlen  = q_tsize[i];
      end
      if (pop_sel[i]) begin
        raddr = q_start[i] + q_head[i];
        rlen  = q_tsize[i];
      end
    end
  end

  tokq_mem #(.MEM_WORDS(MEM_WORDS), .DATA_W(DATA_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (|push_do),
    .waddr_i(waddr),
    .wlen_i (wlen),
    .wdata_i(push_data_i),
    .raddr_i(raddr),
    .rlen_i (rlen),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_rsp_o    <= 1'b0;
      pop_ok_o     <= 1'b0;
      pop_data_o   <= '0;
      push_total_o <= '0;
      pop_total_o  <= '0;
    end else begin
      pop_rsp_o  <= pop_fire;
      pop_ok_o   <= |pop_do;
      pop_data_o <= (|pop_do) ? rdata : '0;
      if (|push_do) push_total_o <= push_total_o + CNT_W'(1);
      if (|pop_do)  pop_total_o  <= pop_total_o + CNT_W'(1);
    end
  end

  always_comb begin
    irq_set                = '0;
    irq_set[IRQ_PUSH_FULL] = |push_err;
    irq_set[IRQ_POP_EMPTY] = |pop_err;
  end

  tokq_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (irq_set),
    .test_i(irq_test_i),
    .clr_i (irq_clr_i),
    .mask_i(irq_mask_i),
    .sts_o (irq_sts_o),
    .irq_o (irq_o)
  );

  assert_one_push_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_do) && $onehot0(pop_do));
  assert_port_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_do & pop_do) == '0);
  assert_rsp_next_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_fire |=> pop_rsp_o);
  assert_rej_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_rsp_o && !pop_ok_o) |-> (pop_data_o == '0));
  assert_total_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|push_do) |=> (push_total_o == $past(push_total_o) + CNT_W'(1)));
  assert_full_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|push_err) |=> irq_sts_o[IRQ_PUSH_FULL]);
endmodule

// File: tb/tokq_mgr_test.sv
module tokq_mgr_test;
  localparam int NQ = 4, MW = 32, DW = 16, CW = 6;
  localparam int QW = 2, AW = 5, SW = 6, TW = 4 * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cfg_we = 0, cfg_en = 0;
  logic [QW-1:0] cfg_q = 0, push_q = 0, pop_q = 0;
  logic [1:0] cfg_tsize = 0, irq_mask = 0, irq_test = 0, irq_clr = 0, irq_sts;
  logic [AW-1:0] cfg_start = 0;
  logic [SW-1:0] cfg_size = 0;
  logic push_valid = 0, pop_valid = 0, pop_ready, pop_rsp, pop_ok, irq;
  logic [TW-1:0] push_data = 0, pop_data;
  logic [NQ*SW-1:0] space;
  logic [CW-1:0] push_total, pop_total;

  tokq_mgr #(.NUM_Q(NQ), .MEM_WORDS(MW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_q_i(cfg_q), .cfg_en_i(cfg_en), .cfg_tsize_i(cfg_tsize),
    .cfg_start_i(cfg_start), .cfg_size_i(cfg_size),
    .push_valid_i(push_valid), .push_q_i(push_q), .push_data_i(push_data),
    .pop_valid_i(pop_valid), .pop_q_i(pop_q), .pop_ready_o(pop_ready),
    .pop_rsp_o(pop_rsp), .pop_ok_o(pop_ok), .pop_data_o(pop_data),
    .space_o(space), .push_total_o(push_total), .pop_total_o(pop_total),
    .irq_mask_i(irq_mask), .irq_test_i(irq_test), .irq_clr_i(irq_clr),
    .irq_sts_o(irq_sts), .irq_o(irq)
  );

  int errors = 0, checks = 0;
  string phase = "reset";

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s: got %h expected %h", req, phase, what, got, exp);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] m_mem [MW];
  bit   m_en [NQ];
  int   m_tl [NQ], m_start [NQ], m_size [NQ], m_head [NQ], m_tail [NQ], m_cnt [NQ];
  int   m_push_tot, m_pop_tot;
  bit [1:0] m_sts;
  bit   m_rsp, m_ok;
  logic [TW-1:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    bit rdy;
    bit [1:0] set;
    int q;
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        m_en[i] = 0; m_tl[i] = 1; m_start[i] = 0; m_size[i] = 0;
        m_head[i] = 0; m_tail[i] = 0; m_cnt[i] = 0;
      end
      m_push_tot = 0; m_pop_tot = 0; m_sts = 0; m_rsp = 0; m_ok = 0; m_data = '0;
    end else begin
      rdy = !(push_valid && pop_valid && push_q == pop_q);
      set = 0;
      m_rsp = pop_valid && rdy; m_ok = 0; m_data = '0;
      if (pop_valid && rdy) begin
        q = int'(pop_q);
        if (!(cfg_we && int'(cfg_q) == q) && m_en[q]) begin
          if (m_cnt[q] == 0) set[1] = 1;
          else begin
            for (int w = 0; w < m_tl[q]; w++)
              m_data[w*DW +: DW] = m_mem[(m_start[q] + m_head[q] + w) % MW];
            m_head[q] = (m_head[q] + m_tl[q] >= m_size[q]) ? 0 : m_head[q] + m_tl[q];
            m_cnt[q]--; m_ok = 1; m_pop_tot++;
          end
        end
      end
      if (push_valid) begin
        q = int'(push_q);
        if (!(cfg_we && int'(cfg_q) == q) && m_en[q]) begin
          if (m_cnt[q] == m_size[q] / m_tl[q]) set[0] = 1;
          else begin
            for (int w = 0; w < m_tl[q]; w++)
              m_mem[(m_start[q] + m_tail[q] + w) % MW] = push_data[w*DW +: DW];
            m_tail[q] = (m_tail[q] + m_tl[q] >= m_size[q]) ? 0 : m_tail[q] + m_tl[q];
            m_cnt[q]++; m_push_tot++;
          end
        end
      end
      if (cfg_we) begin
        q = int'(cfg_q);
        m_en[q] = cfg_en; m_tl[q] = int'(cfg_tsize) + 1;
        m_start[q] = int'(cfg_start); m_size[q] = int'(cfg_size);
        m_head[q] = 0; m_tail[q] = 0; m_cnt[q] = 0;
      end
      m_sts = (m_sts & ~irq_clr) | set | irq_test;
    end
  end

  // compare every cycle, after inputs settle and away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      for (int i = 0; i < NQ; i++)
        chk("R10", $sformatf("space q%0d", i), 64'(space[i*SW +: SW]),
            64'(m_size[i] / m_tl[i] - m_cnt[i]));
      chk("R11", "push_total", 64'(push_total), 64'(m_push_tot % 64));
      chk("R11", "pop_total", 64'(pop_total), 64'(m_pop_tot % 64));
      chk("R8", "irq_sts", 64'(irq_sts), 64'(m_sts));
      chk("R9", "irq", 64'(irq), 64'(|(m_sts & irq_mask)));
      chk("R12", "pop_ready", 64'(pop_ready), 64'(!(push_valid && pop_valid && push_q == pop_q)));
      chk("R13", "pop_rsp", 64'(pop_rsp), 64'(m_rsp));
      chk("R7", "pop_ok", 64'(pop_ok), 64'(m_ok));
      chk("R1", "pop_data", pop_data, m_data);
    end
  end

  task automatic go(bit pv = 0, int pq = 0, logic [TW-1:0] pd = '0,
                    bit ov = 0, int oq = 0, bit [1:0] clr = 0, bit [1:0] tst = 0);
    @(negedge clk);
    cfg_we = 0; push_valid = pv; push_q = QW'(pq); push_data = pd;
    pop_valid = ov; pop_q = QW'(oq); irq_clr = clr; irq_test = tst;
  endtask

  task automatic cfg(int q, bit en, int ts, int st, int sz);
    @(negedge clk);
    cfg_we = 1; cfg_q = QW'(q); cfg_en = en; cfg_tsize = 2'(ts);
    cfg_start = AW'(st); cfg_size = SW'(sz);
    push_valid = 0; pop_valid = 0; irq_clr = 0; irq_test = 0;
  endtask

  function automatic logic [TW-1:0] tok(int n);
    for (int w = 0; w < 4; w++) tok[w*DW +: DW] = DW'(n * 16 + w + 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk("R11", "reset push_total", 64'(push_total), 0);
    chk("R9", "reset irq", 64'(irq), 0);
    chk("R13", "reset pop_rsp", 64'(pop_rsp), 0);

    phase = "R5";
    cfg(0, 0, 2, 0, 6);
    go(1, 0, tok(1)); go(0, 0, '0, 1, 0); go(); go();

    phase = "R1";
    cfg(0, 1, 2, 0, 6);
    go(1, 0, tok(2)); go(0, 0, '0, 1, 0); go(); go();

    phase = "R6";
    go(1, 0, tok(3)); go(1, 0, tok(4)); go(1, 0, tok(5)); go();

    phase = "R8";
    go(0, 0, '0, 0, 0, 2'b10); go(0, 0, '0, 0, 0, 2'b00); go(0, 0, '0, 0, 0, 2'b01); go();

    phase = "R7";
    go(0, 0, '0, 1, 0); go(0, 0, '0, 1, 0); go(0, 0, '0, 1, 0); go(); go();

    phase = "R2";
    for (int k = 0; k < 5; k++) begin
      go(1, 0, tok(10 + k)); go(1, 0, tok(20 + k)); go(0, 0, '0, 1, 0); go(0, 0, '0, 1, 0);
    end
    go();

    phase = "R8";
    go(0, 0, '0, 1, 0, 2'b10); go(); go(0, 0, '0, 0, 0, 2'b11); go();

    phase = "R9";
    irq_mask = 2'b00; go(0, 0, '0, 0, 0, 2'b00, 2'b01); go();
    irq_mask = 2'b01; go(); irq_mask = 2'b10; go(0, 0, '0, 0, 0, 2'b00, 2'b10); go();
    irq_mask = 2'b11; go(0, 0, '0, 0, 0, 2'b11); go();

    phase = "R12";
    go(1, 0, tok(30), 1, 0); go(0, 0, '0, 1, 0); go(); go();

    phase = "R4";
    go(1, 0, tok(31)); go(1, 0, tok(32)); cfg(0, 1, 2, 0, 6); go(0, 0, '0, 1, 0); go();
    go(1, 0, tok(33)); cfg(0, 1, 2, 0, 6); @(negedge clk); push_valid = 1; push_q = 0; pop_valid = 1; pop_q = 1;
    go(0, 0, '0, 0, 0, 2'b11); go();

    phase = "R1";
    for (int ts = 0; ts < 4; ts++) begin
      cfg(1, 1, ts, 8, (ts + 1) * 2);
      go(1, 1, tok(40 + ts)); go(1, 1, tok(50 + ts)); go(1, 1, tok(60 + ts));
      go(0, 0, '0, 1, 1); go(0, 0, '0, 1, 1); go(); go(0, 0, '0, 0, 0, 2'b11);
    end
    go();

    phase = "R3";
    cfg(0, 1, 2, 0, 6); cfg(1, 1, 2, 3, 6);
    go(1, 0, tok(70)); go(1, 0, tok(71)); go(1, 1, tok(72));
    go(0, 0, '0, 1, 0); go(0, 0, '0, 1, 0); go(0, 0, '0, 1, 1); go(); go();

    phase = "R11";
    cfg(0, 1, 2, 0, 6); cfg(1, 1, 1, 8, 8); cfg(2, 1, 0, 16, 4); cfg(3, 1, 3, 20, 12);
    for (int n = 0; n < 3000; n++) begin
      if (n % 97 == 0) irq_mask = 2'($urandom);
      go($urandom % 2 == 0, int'($urandom % 4), {$urandom, $urandom},
         $urandom % 2 == 0, int'($urandom % 4),
         ($urandom % 8 == 0) ? 2'($urandom) : 2'b00,
         ($urandom % 64 == 0) ? 2'($urandom) : 2'b00);
    end
    go(); go(); go();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule